// File: doc/BRIEF.md
# Off-Board Bus Cycle Timeout Guard

This block keeps the processor from hanging on a system-bus access that nobody answers. Whenever a bus cycle begins toward an off-board address while the guard is enabled, a counter starts. If the bus acknowledge does not arrive within a fixed number of clock cycles, the guard produces a one-cycle forced-ready pulse. The pulse is merged into the processor's ready logic so that the stalled cycle completes and execution carries on, rather than the processor adding wait states forever.

At the moment of each forced completion the block also sets a sticky timeout flag. This flag can be wired to an interrupt request so that software learns that an access went to an empty address. The flag stays set until a clear input is pulsed. Cycles that stay on the board never arm the counter. A configuration enable switches the whole function on or off. The timeout length is a parameter in clock cycles; the default of 98,300 cycles gives roughly 10 ms at 9.83 MHz.

Top module: `bus_timeout_guard`

## Requirements
- R1: After synchronous reset, `force_rdy` and `tmo_flag` are both 0.
- R2: A `cyc_start` sampled high with `offboard` and `en` high at clock edge E0 arms the guard. If nothing cancels it, `force_rdy` is high in the cycle that follows edge E0+TIMEOUT_CYCLES.
- R3: An `ack` sampled high at any edge after E0, up to and including the edge on which the timeout would fire, ends the watch with no forced-ready pulse.
- R4: A `cyc_start` with `offboard` low never arms the guard and never leads to a `force_rdy` pulse.
- R5: With `en` low, a strobe does not arm the guard. If `en` is sampled low at any edge while the guard is armed, the watch is abandoned and no pulse follows.
- R6: `force_rdy` is high for exactly one cycle per expiry. It does not rise again until a new arming strobe has been seen.
- R7: `tmo_flag` rises on the same edge as `force_rdy` and stays high until `flag_clr` is sampled high. A clear with no expiry on that edge brings it to 0.
- R8: If `flag_clr` and an expiry fall on the same edge, `tmo_flag` is 1 after that edge.
- R9: A `cyc_start` sampled while the guard is armed restarts the count from that edge if `offboard` is high, and cancels the watch if `offboard` is low. A strobe on the expiry edge takes priority over the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the guard function |
| cyc_start | input | 1 | One-cycle strobe marking the start of a bus cycle |
| offboard | input | 1 | Qualifies the strobe as an off-board system-bus cycle |
| ack | input | 1 | Bus acknowledge for the current cycle |
| flag_clr | input | 1 | Clears the sticky timeout flag |
| force_rdy | output | 1 | One-cycle forced-ready pulse to the processor |
| tmo_flag | output | 1 | Sticky timeout flag, usable as an interrupt request |

## Verification
Several properties are checked on every cycle: the forced-ready pulse lasts one cycle; it never follows an edge that carried an acknowledge, a strobe or a low enable; it always comes with the flag set; the flag stays set unless cleared; and a checker-side counter shows that each pulse lands exactly TIMEOUT_CYCLES edges after the last strobe. Other behaviours can only be shown by the bench's scenarios. These include the fact that an unanswered off-board strobe really does fire, that on-board and disabled strobes never do, the cancel and restart cases swept across every edge position, and the precedence of a set over a clear on the flag.

// File: rtl/bto_pkg.sv
package bto_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } bto_state_e;

    typedef struct packed {
        logic cnt_clr;
        logic cnt_inc;
        logic fire;
    } bto_ctl_t;

    typedef struct packed {
        logic en;
        logic strobe;
        logic offboard;
        logic ack;
    } bto_evt_t;

    function automatic bto_state_e bto_next_state(
        input bto_state_e cur,
        input bto_evt_t   ev,
        input logic       at_limit
    );
        bto_state_e nxt;
        nxt = cur;
        if (ev.strobe) begin
            nxt = (ev.en && ev.offboard) ? ST_WAIT : ST_IDLE;
        end else if (cur == ST_WAIT) begin
            if (!ev.en || ev.ack || at_limit) begin
                nxt = ST_IDLE;
            end
        end
        return nxt;
    endfunction

    function automatic bto_ctl_t bto_decide(
        input bto_state_e cur,
        input bto_evt_t   ev,
        input logic       at_limit
    );
        bto_ctl_t c;
        c = '0;
        if (ev.strobe) begin
            c.cnt_clr = 1'b1;
        end else if (cur == ST_WAIT && ev.en && !ev.ack) begin
            if (at_limit) begin
                c.fire = 1'b1;
            end else begin
                c.cnt_inc = 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/bto_counter.sv
module bto_counter #(
    parameter int unsigned LIMIT = 98300
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/bto_tracker.sv
module bto_tracker
    import bto_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bto_evt_t ev,
    input  logic     at_limit,
    output logic     cnt_clr,
    output logic     cnt_inc,
    output logic     fire,
    output logic     force_q
);
    bto_state_e state_q;
    bto_ctl_t   ctl;

    always_comb begin
        ctl = bto_decide(state_q, ev, at_limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            force_q <= 1'b0;
        end else begin
            state_q <= bto_next_state(state_q, ev, at_limit);
            force_q <= ctl.fire;
        end
    end

    assign cnt_clr = ctl.cnt_clr;
    assign cnt_inc = ctl.cnt_inc;
    assign fire    = ctl.fire;
endmodule

// File: rtl/bto_flag.sv
module bto_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_timeout_guard.sv
module bus_timeout_guard
    import bto_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 98300
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cyc_start,
    input  logic offboard,
    input  logic ack,
    input  logic flag_clr,
    output logic force_rdy,
    output logic tmo_flag
);
    bto_evt_t ev;
    logic     at_limit;
    logic     cnt_clr;
    logic     cnt_inc;
    logic     fire;

    assign ev = '{en: en, strobe: cyc_start, offboard: offboard, ack: ack};

    bto_counter #(.LIMIT(TIMEOUT_CYCLES)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .at_limit (at_limit)
    );

    bto_tracker u_trk (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .at_limit (at_limit),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .fire     (fire),
        .force_q  (force_rdy)
    );

    bto_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (fire),
        .clr  (flag_clr),
        .flag (tmo_flag)
    );
endmodule

// File: rtl/bus_timeout_guard_chk.sv
module bus_timeout_guard_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 98300
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cyc_start,
    input logic ack,
    input logic flag_clr,
    input logic force_rdy,
    input logic tmo_flag
);
    localparam int unsigned WW = $clog2(TIMEOUT_CYCLES + 2) + 1;
    localparam logic [WW-1:0] SAT = WW'(TIMEOUT_CYCLES + 1);

    logic [WW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst || cyc_start) begin
            since_q <= '0;
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        force_rdy |=> !force_rdy);

    // R3
    ack_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !cyc_start) |=> !force_rdy);

    // R5
    en_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !force_rdy);

    // R9
    strobe_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> !force_rdy);

    // R7
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        force_rdy |-> tmo_flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_flag && !flag_clr) |=> tmo_flag);

    // R2
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        force_rdy |-> (since_q == WW'(TIMEOUT_CYCLES)));
endmodule

bind bus_timeout_guard bus_timeout_guard_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cyc_start (cyc_start),
    .ack       (ack),
    .flag_clr  (flag_clr),
    .force_rdy (force_rdy),
    .tmo_flag  (tmo_flag)
);

// File: tb/bus_timeout_guard_tb.sv
module bus_timeout_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int T = 8;

    logic clk = 1'b0;
    logic rst, en, cyc_start, offboard, ack, flag_clr;
    logic force_rdy, tmo_flag;

    int checks = 0;
    int fails  = 0;

    int p_offb, p_en, p_ack, p_drop, p_rs, p_roff, p_clr;
    int got_n, got_first;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_timeout_guard #(.TIMEOUT_CYCLES(T)) u_dut (
        .clk(clk), .rst(rst), .en(en), .cyc_start(cyc_start),
        .offboard(offboard), .ack(ack), .flag_clr(flag_clr),
        .force_rdy(force_rdy), .tmo_flag(tmo_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive the inputs that edge j after the strobe edge will sample
    task automatic drive_for(input int j);
        ack       = (p_ack == j);
        en        = (p_en != 0) && !(p_drop > 0 && j >= p_drop);
        cyc_start = (p_rs == j);
        offboard  = (p_rs == j) ? (p_roff != 0) : 1'b0;
        flag_clr  = (p_clr == j);
    endtask

    task automatic run_cycle();
        got_n = 0;
        got_first = 0;
        @(negedge clk);
        cyc_start = 1'b1;
        offboard  = (p_offb != 0);
        en        = (p_en != 0);
        ack = 1'b0;
        flag_clr = (p_clr == 0) ? 1'b0 : 1'b0;
        @(negedge clk);
        drive_for(1);
        for (int k = 1; k <= 2*T + 6; k++) begin
            @(negedge clk);
            if (force_rdy) begin
                got_n++;
                if (got_first == 0) got_first = k;
            end
            drive_for(k + 1);
        end
        cyc_start = 1'b0; ack = 1'b0; flag_clr = 1'b0; en = 1'b1; offboard = 1'b0;
    endtask

    function automatic int expected_edge();
        int base;
        int fe;
        if (p_en == 0) return 0;
        base = -1;
        if (p_offb != 0) base = 0;
        if (p_rs > 0 && p_rs <= T) base = (p_roff != 0) ? p_rs : -1;
        if (base < 0) return 0;
        fe = base + T;
        if (p_ack > base && p_ack <= fe) return 0;
        if (p_drop > 0 && p_drop <= fe) return 0;
        return fe;
    endfunction

    task automatic scenario(input string req);
        int fe;
        int prev;
        int exp_flag;
        prev = tmo_flag;
        fe = expected_edge();
        run_cycle();
        check({req, " pulse count"}, got_n, (fe > 0) ? 1 : 0);
        check({req, " pulse edge"}, got_first, fe);
        if (fe > 0) exp_flag = (p_clr == 0 || p_clr <= fe) ? 1 : 0;
        else        exp_flag = (prev != 0 && p_clr == 0) ? 1 : 0;
        check({req, " flag"}, tmo_flag, exp_flag);
    endtask

    task automatic defaults();
        p_offb = 1; p_en = 1; p_ack = 0; p_drop = 0; p_rs = 0; p_roff = 0; p_clr = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        check("R7 clear", tmo_flag, 0);
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; cyc_start = 1'b0; offboard = 1'b0; ack = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        check("R1 force_rdy", force_rdy, 0);
        check("R1 tmo_flag", tmo_flag, 0);

        // R2 and R6: unanswered off-board cycle, one pulse only
        defaults();
        scenario("R2 R6 unanswered");
        clear_flag();

        // R3 and R4: acknowledge at every edge position, off-board and on-board
        for (int o = 0; o <= 1; o++) begin
            for (int a = 1; a <= T + 2; a++) begin
                defaults(); p_offb = o; p_ack = a;
                scenario(o ? "R3 ack sweep" : "R4 onboard");
                if (tmo_flag) clear_flag();
            end
        end

        // R5: disabled strobe, then enable dropped at each position
        defaults(); p_en = 0;
        scenario("R5 disabled");
        for (int d = 1; d <= T + 1; d++) begin
            defaults(); p_drop = d;
            scenario("R5 enable drop");
            if (tmo_flag) clear_flag();
        end

        // R9: restart by a second strobe, off-board or on-board
        for (int ro = 0; ro <= 1; ro++) begin
            for (int r = 1; r <= T; r++) begin
                defaults(); p_rs = r; p_roff = ro;
                scenario("R9 restart");
                if (tmo_flag) clear_flag();
            end
        end

        // R7: flag held across a later cycle with no clear
        defaults();
        scenario("R7 set");
        defaults(); p_ack = 2;
        scenario("R7 hold");
        // R8: clear on the expiry edge, and clear before it
        defaults(); p_clr = T;
        scenario("R8 same edge");
        defaults(); p_clr = 3;
        scenario("R8 early clear");
        // R7: clear after expiry
        defaults(); p_clr = T + 2;
        scenario("R7 late clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule